// File: doc/BRIEF.md
# Time-Shared Pseudo Dual-Port RAM

This block is a synchronous memory with one write port and one read port. Both ports may be used in the same clock cycle, but the storage behind them has only one access port. The clock period is split into two halves. While the clock is high the array serves the read address. While the clock is low it serves the write address. A per-bit two-way address multiplexer, driven by the clock level, shares the array between the two accesses. No second clock is needed.

All port inputs are captured in registers on the rising edge. Read data appears through an output latch during the high half of the cycle that follows the capturing edge. It keeps its value until another read is captured. In a cycle that carries both a read and a write, the read half runs first. A read of the address being written in that cycle therefore returns the old contents, and the new contents are visible to reads from the next cycle on. The word is built from a parameterised number of 9-bit lanes, and the depth is a parameter between 128 and 4096 words.

Top module: `tspr_ram`

## Requirements
- R1: The word width is LANES × 9 bits with LANES ≥ 1. DEPTH must be a power of two from 128 to 4096, and any other value stops elaboration. The address width is log2(DEPTH).
- R2: When wr_en_i is high at a rising edge, wr_data_i is stored at wr_addr_i. A read captured at any later edge returns that word, including at addresses 0 and DEPTH-1.
- R3: When rd_en_i is high at a rising edge, rd_data_o shows the word stored at rd_addr_i by the falling edge of that cycle. It keeps that word through the low half.
- R4: A read and a write captured at the same edge to different addresses both complete. The read returns the stored word, and the write is visible to the next read.
- R5: A read and a write captured at the same edge to the same address return the contents from before that write. A read in the following cycle returns the new data.
- R6: When rd_en_i is low at a rising edge, rd_data_o keeps its previous value through that cycle. This holds even if the same edge captures a write to the address last read.
- R7: A cycle with both enables low changes neither the stored words nor rd_data_o.
- R8: Only the values present at the rising edge count. Changes to the addresses or data after the edge do not alter the read result of that cycle.
- R9: While rst_n is low, rd_data_o is 0 and captured enables are cleared, so no write takes place. After release, rd_data_o stays 0 until the first read.
- R10: The array address equals the captured read address while the clock is high and the captured write address while the clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; its high half is the read phase and its low half the write phase |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write request, sampled at the rising edge |
| wr_addr_i | input | log2(DEPTH) | Write address |
| wr_data_i | input | LANES*9 | Write data |
| rd_en_i | input | 1 | Read request, sampled at the rising edge |
| rd_addr_i | input | log2(DEPTH) | Read address |
| rd_data_o | output | LANES*9 | Latched read data |

## Verification
The bench builds the block with LANES = 2 and DEPTH = 128, which gives an 18-bit word and a 7-bit address. At the smallest legal depth, both end addresses and every repeat of an address are reachable within a short random run. Two lanes show that each 9-bit slice travels on its own path. The run covers these cases:
- same-cycle read and write on the same and on different addresses
- writes under a suppressed read
- a reset applied in the middle of traffic

// File: rtl/tspr_pkg.sv
package tspr_pkg;
   localparam int unsigned LANE_W    = 9;
   localparam int unsigned DEPTH_MIN = 128;
   localparam int unsigned DEPTH_MAX = 4096;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/tspr_capture.sv
// Rising-edge capture of every port input.
module tspr_capture #(
   parameter int unsigned AW = 7,
   parameter int unsigned DW = 18
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   output logic          wr_en_q,
   output logic [AW-1:0] wr_addr_q,
   output logic [DW-1:0] wr_data_q,
   output logic [AW-1:0] rd_addr_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en_q   <= 1'b0;
         wr_addr_q <= '0;
         wr_data_q <= '0;
         rd_addr_q <= '0;
      end else begin
         wr_en_q   <= wr_en;
         wr_addr_q <= wr_addr;
         wr_data_q <= wr_data;
         if (rd_en) rd_addr_q <= rd_addr;
      end
   end
endmodule

// File: rtl/tspr_rd_gate.sv
// Arms the read latch for the high half after a captured read.
// A toggle is flipped on the rising edge and copied on the falling edge.
// The pair differs only between those two edges of a read cycle.
module tspr_rd_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_en,
   output logic rd_armed
);
   logic tog_rise;
   logic tog_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     tog_rise <= 1'b0;
      else if (rd_en) tog_rise <= ~tog_rise;
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) tog_fall <= 1'b0;
      else        tog_fall <= tog_rise;
   end

   assign rd_armed = tog_rise ^ tog_fall;
endmodule

// File: rtl/tspr_addr_mux.sv
// One 2-input selector per address bit, steered by the clock level.
module tspr_addr_mux #(
   parameter int unsigned AW = 7
) (
   input  logic          rd_phase,
   input  logic [AW-1:0] rd_addr_q,
   input  logic [AW-1:0] wr_addr_q,
   output logic [AW-1:0] ary_addr
);
   for (genvar b = 0; b < AW; b++) begin : g_bit
      assign ary_addr[b] = rd_phase ? rd_addr_q[b] : wr_addr_q[b];
   end
endmodule

// File: rtl/tspr_lane.sv
// One 9-bit slice of the array with its output latch.
module tspr_lane #(
   parameter int unsigned AW    = 7,
   parameter int unsigned DEPTH = 128
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_commit,
   input  logic [AW-1:0]               wr_addr_q,
   input  logic [tspr_pkg::LANE_W-1:0] wr_word,
   input  logic                        rd_armed,
   input  logic [AW-1:0]               ary_addr,
   output logic [tspr_pkg::LANE_W-1:0] rd_word
);
   import tspr_pkg::*;

   logic [LANE_W-1:0] cells [DEPTH];

   // The write commits at the rising edge that closes the write half.
   always_ff @(posedge clk) begin
      if (wr_commit) cells[wr_addr_q] <= wr_word;
   end

   // Transparent only in the armed read half; holds otherwise.
   always_latch begin
      if (!rst_n)                 rd_word = '0;
      else if (clk && rd_armed)   rd_word = cells[ary_addr];
   end
endmodule

// File: rtl/tspr_ram.sv
module tspr_ram #(
   parameter int unsigned LANES = 2,
   parameter int unsigned DEPTH = 1024,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned DW   = LANES * tspr_pkg::LANE_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en_i,
   input  logic [AW-1:0] wr_addr_i,
   input  logic [DW-1:0] wr_data_i,
   input  logic          rd_en_i,
   input  logic [AW-1:0] rd_addr_i,
   output logic [DW-1:0] rd_data_o
);
   import tspr_pkg::*;

   if (LANES < 1) begin : g_bad_lanes
      $error("tspr_ram: LANES must be at least 1");
   end
   if (DEPTH < DEPTH_MIN || DEPTH > DEPTH_MAX) begin : g_bad_depth_range
      $error("tspr_ram: DEPTH out of the 128..4096 range");
   end
   if (!is_pow2(DEPTH)) begin : g_bad_depth_pow2
      $error("tspr_ram: DEPTH must be a power of two");
   end

   logic          wr_en_q;
   logic [AW-1:0] wr_addr_q;
   logic [DW-1:0] wr_data_q;
   logic [AW-1:0] rd_addr_q;
   logic          rd_armed;
   logic [AW-1:0] ary_addr;

   tspr_capture #(.AW(AW), .DW(DW)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en_i),
      .wr_addr  (wr_addr_i),
      .wr_data  (wr_data_i),
      .rd_en    (rd_en_i),
      .rd_addr  (rd_addr_i),
      .wr_en_q  (wr_en_q),
      .wr_addr_q(wr_addr_q),
      .wr_data_q(wr_data_q),
      .rd_addr_q(rd_addr_q)
   );

   tspr_rd_gate u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en_i),
      .rd_armed(rd_armed)
   );

   tspr_addr_mux #(.AW(AW)) u_amux (
      .rd_phase (clk),
      .rd_addr_q(rd_addr_q),
      .wr_addr_q(wr_addr_q),
      .ary_addr (ary_addr)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      tspr_lane #(.AW(AW), .DEPTH(DEPTH)) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_commit(wr_en_q),
         .wr_addr_q(wr_addr_q),
         .wr_word  (wr_data_q[l*LANE_W +: LANE_W]),
         .rd_armed (rd_armed),
         .ary_addr (ary_addr),
         .rd_word  (rd_data_o[l*LANE_W +: LANE_W])
      );
   end
endmodule

// File: rtl/tspr_ram_chk.sv
module tspr_ram_chk #(
   parameter int unsigned AW = 7,
   parameter int unsigned DW = 18
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rd_en_i,
   input logic [DW-1:0] rd_data_o,
   input logic [AW-1:0] ary_addr,
   input logic [AW-1:0] rd_addr_q,
   input logic [AW-1:0] wr_addr_q
);
   // R6
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en_i |=> $stable(rd_data_o));

   // R9
   rst_clear_chk: assert property (@(posedge clk)
      !rst_n |-> (rd_data_o == '0));

   // R10
   wr_phase_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ary_addr == wr_addr_q);

   // R10
   rd_phase_addr_chk: assert property (@(negedge clk) disable iff (!rst_n)
      ary_addr == rd_addr_q);
endmodule

bind tspr_ram tspr_ram_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_en_i  (rd_en_i),
   .rd_data_o(rd_data_o),
   .ary_addr (ary_addr),
   .rd_addr_q(rd_addr_q),
   .wr_addr_q(wr_addr_q)
);

// File: tb/tspr_ram_tb_top.sv
module tspr_ram_tb_top;
   localparam int unsigned LANES = 2;
   localparam int unsigned DEPTH = 128;
   localparam int unsigned AW    = $clog2(DEPTH);
   localparam int unsigned DW    = LANES * 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   logic [DW-1:0] ref_mem [DEPTH];
   logic [DW-1:0] last_exp = '0;
   logic [DW-1:0] exp_q [$];
   string         tag_q [$];
   logic [31:0]   lcg = 32'h1234_5678;

   always #2 clk = ~clk;

   tspr_ram #(.LANES(LANES), .DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
   );

   function automatic logic [DW-1:0] pat(input int i);
      return DW'((i * 37 + 5) ^ (i << 9) ^ 18'h2A5C3);
   endfunction

   task automatic check_now(input string tag, input logic [DW-1:0] act,
                            input logic [DW-1:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // Driver: called at rising edge + 1; returns one cycle later.
   task automatic cyc(input logic we, input int wa, input logic [DW-1:0] wd,
                      input logic re, input int ra, input string tag);
      logic [DW-1:0] e;
      wr_en   = we;
      wr_addr = AW'(wa);
      wr_data = wd;
      rd_en   = re;
      rd_addr = AW'(ra);
      @(posedge clk);
      e = re ? ref_mem[ra] : last_exp;
      last_exp = e;
      if (we) ref_mem[wa] = wd;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      #1;
   endtask

   // Monitor: compares in the low half of each cycle.
   initial begin
      forever begin
         @(posedge clk);
         #3;
         if (exp_q.size() != 0) begin
            logic [DW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check_now(t, rd_data, e);
         end
      end
   end

   initial begin
      #(4 * 100000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      // R1: word width from the lane count
      check_now("R1 width", DW'($bits(rd_data)), DW'(LANES * 9));

      repeat (4) @(posedge clk);
      #1;
      check_now("R9 in reset", rd_data, '0);
      rst_n = 1'b1;
      check_now("R9 after release", rd_data, '0);
      cyc(0, 3, pat(99), 0, 4, "R9 idle after reset");

      // R2 / R3: fill then read back
      for (int i = 0; i < 16; i++) cyc(1, i, pat(i), 0, 0, "R2 write hold");
      for (int i = 0; i < 16; i++) cyc(0, 0, '0, 1, i, "R3 read back");
      cyc(1, DEPTH - 1, pat(500), 0, 0, "R2 top write");
      cyc(1, 0, pat(501), 0, 0, "R2 bottom write");
      cyc(0, 0, '0, 1, DEPTH - 1, "R2 top read");
      cyc(0, 0, '0, 1, 0, "R2 bottom read");

      // R4 / R10: combined cycle on different addresses
      cyc(1, 20, pat(200), 1, 3, "R4/R10 combined read");
      cyc(0, 0, '0, 1, 20, "R4/R10 combined write visible");

      // R5: same address in one cycle
      cyc(1, 5, pat(300), 1, 5, "R5 old contents");
      cyc(1, 5, pat(301), 1, 5, "R5 old contents again");
      cyc(0, 0, '0, 1, 5, "R5 new contents");

      // R6: write under a suppressed read
      cyc(0, 0, '0, 1, 7, "R6 prime");
      cyc(1, 7, pat(400), 0, 9, "R6 hold on write");
      cyc(0, 0, '0, 1, 7, "R6 later read");

      // R7: idle cycles change nothing
      for (int i = 0; i < 4; i++) cyc(0, i, pat(600 + i), 0, 11 + i, "R7 idle hold");
      cyc(0, 0, '0, 1, 1, "R7 array intact");
      cyc(0, 0, '0, 1, 2, "R7 array intact");

      // R8: inputs moved right after the edge
      cyc(0, 0, '0, 1, 10, "R8 edge value");
      cyc(0, 12, pat(700), 0, 13, "R8 later change ignored");

      // R9: reset in mid traffic ignores a write request
      cyc(1, 30, pat(800), 0, 0, "R9 preload");
      cyc(0, 0, '0, 1, 30, "R9 preload read");
      @(posedge clk);
      #1;
      rst_n   = 1'b0;
      wr_en   = 1'b1;
      wr_addr = AW'(30);
      wr_data = pat(801);
      rd_en   = 1'b1;
      rd_addr = AW'(30);
      repeat (3) @(posedge clk);
      #1;
      check_now("R9 mid reset", rd_data, '0);
      rst_n = 1'b1;
      last_exp = '0;
      cyc(0, 0, '0, 0, 0, "R9 zero until read");
      cyc(0, 0, '0, 1, 30, "R9 no write in reset");

      // Mixed random traffic on a small address window
      for (int i = 0; i < 64; i++) cyc(1, i, pat(1000 + i), 0, 0, "R2 fill");
      for (int i = 0; i < 400; i++) begin
         lcg = lcg * 32'd1103515245 + 32'd12345;
         cyc(lcg[16], int'(lcg[22:17]), pat(int'(lcg[31:20])),
             lcg[24], int'(lcg[30:25]), "R4 mixed");
      end

      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule